// File: doc/BRIEF.md
# DS1 Synchronization Status Message Processor

This block handles the quality messages that travel on the data link of an extended-superframe DS1 line. Each message is a 16-bit bit-oriented code. The receive half takes the data-link bits one strobe at a time and finds the 16-bit boundaries. It votes over recent repetitions and reports the quality level it has accepted. It also flags when that level is worse than the card's own stratum. Framing, CRC checking and the extraction of the data-link bits from the line are done upstream.

The transmit half picks the code to send downstream. The pick depends on the clock mode from the mode controller, the level received on the line and the card's own stratum. It sends that code as an endless run of 16-bit words, most significant bit first. It changes codes only between words.

Top module: `ssm_proc`

## Requirements
- R1: After reset the reported level is "none" (code 7), the loss flag is low, and the first transmitted word is the do-not-use code.
- R2: Six levels exist, ranked best to worst with index 0..5: primary reference 0x04FF, traceability unknown 0x08FF, stratum 2 0x0CFF, stratum 3E 0x7CFF, stratum 3 0x10FF, do-not-use 0x30FF. Words are carried most significant bit first, and index 7 means no level.
- R3: A slot is taken at the first strobe where the last 16 bits form a known code. After that a slot is taken every 16 strobes. A code is accepted in a slot when at least 7 of the last 10 slots, counting this one, hold that code.
- R4: An accepted level is kept until another code reaches the 7-of-10 quorum, or until the no-message timeout.
- R5: When `nomsg_limit` strobes pass without a slot holding a known code, the level returns to 7. At the same moment the vote history is emptied and boundary alignment is dropped.
- R6: `rx_los` is high exactly when a level is accepted and its index is greater than `own_ql`.
- R7: In free-run mode (0) and first-acquisition mode (1) the do-not-use code is transmitted.
- R8: In tracking mode (2) the accepted received code is sent on unchanged. If no level is accepted, the traceability-unknown code is sent.
- R9: In holdover mode (3) the code of `own_ql` is transmitted.
- R10: Output words follow one another with no gap. The next word's code is chosen at the 16th `tx_stb` of the current word, and `tx_ql` changes only then.
- R11: Slots whose 16 bits match no known code count as votes for no level, so they dilute the quorum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_stb | input | 1 | Receive data-link bit strobe |
| dl_bit | input | 1 | Receive data-link bit, valid with `dl_stb` |
| nomsg_limit | input | 16 | Strobe count without a valid message before "none" is declared |
| clk_mode | input | 2 | Clock mode: 0 free run, 1 first acquisition, 2 tracking, 3 holdover |
| own_ql | input | 3 | Card's own stratum as a level index 0..5 |
| tx_stb | input | 1 | Transmit bit strobe; advances `tx_bit` |
| tx_bit | output | 1 | Serial data-link output bit |
| rx_ql | output | 3 | Accepted received level index, 7 when none |
| rx_los | output | 1 | Received level worse than own stratum |
| tx_ql | output | 3 | Level index of the word now being sent |

## Verification
The assertions assume that `own_ql` is always one of the six defined levels. They also assume that `clk_mode` and `own_ql` are held steady around a transmit word boundary. The stimulus sets these inputs only between whole words and draws `own_ql` from 0..5. Receive words are sent back to back and aligned to one another. A corrupted word is always 0x5555, which cannot form a known code at any bit offset together with its neighbours. Because of that, the slot boundaries the bench's model predicts match the ones the design finds.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int CODE_BITS = 16;
  localparam int NUM_LEVELS = 6;

  typedef enum logic [2:0] {
    QL_PRS  = 3'd0,
    QL_STU  = 3'd1,
    QL_ST2  = 3'd2,
    QL_ST3E = 3'd3,
    QL_ST3  = 3'd4,
    QL_DUS  = 3'd5,
    QL_NONE = 3'd7
  } ql_e;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_ACQ1  = 2'd1,
    MODE_TRACK = 2'd2,
    MODE_HOLD  = 2'd3
  } mode_e;

  // message byte of the form 0xxxxxx0, followed by an all-ones byte
  function automatic logic [7:0] ql_msg(ql_e q);
    case (q)
      QL_PRS:  return 8'h04;
      QL_STU:  return 8'h08;
      QL_ST2:  return 8'h0C;
      QL_ST3E: return 8'h7C;
      QL_ST3:  return 8'h10;
      QL_DUS:  return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [CODE_BITS-1:0] ql_code(ql_e q);
    return {ql_msg(q), 8'hFF};
  endfunction

  function automatic ql_e code_ql(logic [CODE_BITS-1:0] w);
    ql_e r;
    r = QL_NONE;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (w == ql_code(ql_e'(3'(i)))) r = ql_e'(3'(i));
    end
    return r;
  endfunction

  // a level with a larger index is of lower quality
  function automatic logic ql_worse(ql_e a, ql_e b);
    return a > b;
  endfunction

  function automatic ql_e pick_tx(mode_e m, ql_e rx, ql_e own);
    case (m)
      MODE_TRACK: return (rx == QL_NONE) ? QL_STU : rx;
      MODE_HOLD:  return own;
      default:    return QL_DUS;
    endcase
  endfunction
endpackage

// File: rtl/ssm_rx_align.sv
module ssm_rx_align
  import ssm_pkg::*;
#(
  parameter int W     = CODE_BITS,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             bit_in,
  input  logic [LIM_W-1:0] limit,
  output logic             slot_evt,
  output ql_e              slot_ql,
  output logic             nomsg_evt
);
  localparam int PW = $clog2(W);

  logic [W-1:0]     window_q;
  logic [W-1:0]     win_next;
  ql_e              win_ql;
  logic             aligned_q;
  logic [PW-1:0]    phase_q;
  logic [LIM_W-1:0] idle_q;
  logic             good_slot;

  assign win_next  = {window_q[W-2:0], bit_in};
  assign win_ql    = code_ql(win_next);
  assign slot_evt  = stb && (aligned_q ? (phase_q == PW'(W-1)) : (win_ql != QL_NONE));
  assign slot_ql   = slot_evt ? win_ql : QL_NONE;
  assign good_slot = slot_evt && (win_ql != QL_NONE);
  assign nomsg_evt = stb && !good_slot &&
                     (({1'b0, idle_q} + {{LIM_W{1'b0}}, 1'b1}) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window_q  <= '0;
      aligned_q <= 1'b0;
      phase_q   <= '0;
      idle_q    <= '0;
    end else if (stb) begin
      window_q <= win_next;
      if (nomsg_evt) begin
        aligned_q <= 1'b0;
        phase_q   <= '0;
        idle_q    <= '0;
      end else begin
        aligned_q <= aligned_q | good_slot;
        idle_q    <= good_slot ? '0 : idle_q + 1'b1;
        if (slot_evt)       phase_q <= '0;
        else if (aligned_q) phase_q <= phase_q + 1'b1;
      end
    end
  end

  // R3: once aligned, two slots are never on consecutive strobes
  p_slot_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_evt && !nomsg_evt) |=> !slot_evt);
endmodule

// File: rtl/ssm_rx_vote.sv
module ssm_rx_vote
  import ssm_pkg::*;
#(
  parameter int WIN  = 10,
  parameter int VMIN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_evt,
  input  ql_e  slot_ql,
  input  logic clear,
  output ql_e  rx_ql
);
  localparam int CW = $clog2(WIN + 1);

  ql_e           hist_q [WIN];
  logic [CW-1:0] votes;

  // the new slot plus the WIN-1 newest stored slots
  always_comb begin
    votes = '0;
    if (slot_ql != QL_NONE) begin
      votes = CW'(1);
      for (int i = 0; i < WIN - 1; i++) begin
        if (hist_q[i] == slot_ql) votes = votes + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) hist_q[i] <= QL_NONE;
      rx_ql <= QL_NONE;
    end else if (clear) begin
      for (int i = 0; i < WIN; i++) hist_q[i] <= QL_NONE;
      rx_ql <= QL_NONE;
    end else if (slot_evt) begin
      hist_q[0] <= slot_ql;
      for (int i = 1; i < WIN; i++) hist_q[i] <= hist_q[i-1];
      if (votes >= CW'(VMIN)) rx_ql <= slot_ql;
    end
  end

  p_need_quorum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_evt && !clear && votes < CW'(VMIN)) |=> $stable(rx_ql));
  p_hold_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_evt || clear) |=> $stable(rx_ql));
endmodule

// File: rtl/ssm_tx_select.sv
module ssm_tx_select
  import ssm_pkg::*;
(
  input  mode_e mode,
  input  ql_e   rx_ql,
  input  ql_e   own_ql,
  output ql_e   next_ql
);
  assign next_ql = pick_tx(mode, rx_ql, own_ql);
endmodule

// File: rtl/ssm_tx_ser.sv
module ssm_tx_ser
  import ssm_pkg::*;
#(
  parameter int W = CODE_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  ql_e  next_ql,
  output logic bit_out,
  output ql_e  cur_ql,
  output logic load
);
  localparam int PW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [PW-1:0] cnt_q;

  assign load    = stb && (cnt_q == PW'(W-1));
  assign bit_out = sh_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= ql_code(QL_DUS);
      cur_ql <= QL_DUS;
      cnt_q  <= '0;
    end else if (stb) begin
      if (load) begin
        sh_q   <= ql_code(next_ql);
        cur_ql <= next_ql;
        cnt_q  <= '0;
      end else begin
        sh_q  <= {sh_q[W-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_word_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cur_ql));
endmodule

// File: rtl/ssm_proc.sv
module ssm_proc
  import ssm_pkg::*;
#(
  parameter int VOTE_WIN = 10,
  parameter int VOTE_MIN = 7,
  parameter int LIM_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dl_stb,
  input  logic             dl_bit,
  input  logic [LIM_W-1:0] nomsg_limit,
  input  logic [1:0]       clk_mode,
  input  logic [2:0]       own_ql,
  input  logic             tx_stb,
  output logic             tx_bit,
  output logic [2:0]       rx_ql,
  output logic             rx_los,
  output logic [2:0]       tx_ql
);
  logic  slot_evt;
  ql_e   slot_ql;
  logic  nomsg_evt;
  ql_e   acc_ql;
  ql_e   next_ql;
  ql_e   cur_ql;
  logic  tx_load;
  mode_e mode;
  ql_e   own;

  assign mode = mode_e'(clk_mode);
  assign own  = ql_e'(own_ql);

  ssm_rx_align #(.W(CODE_BITS), .LIM_W(LIM_W)) u_align (
    .clk(clk), .rst_n(rst_n), .stb(dl_stb), .bit_in(dl_bit),
    .limit(nomsg_limit), .slot_evt(slot_evt), .slot_ql(slot_ql),
    .nomsg_evt(nomsg_evt));

  ssm_rx_vote #(.WIN(VOTE_WIN), .VMIN(VOTE_MIN)) u_vote (
    .clk(clk), .rst_n(rst_n), .slot_evt(slot_evt), .slot_ql(slot_ql),
    .clear(nomsg_evt), .rx_ql(acc_ql));

  ssm_tx_select u_sel (
    .mode(mode), .rx_ql(acc_ql), .own_ql(own), .next_ql(next_ql));

  ssm_tx_ser #(.W(CODE_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .stb(tx_stb), .next_ql(next_ql),
    .bit_out(tx_bit), .cur_ql(cur_ql), .load(tx_load));

  assign rx_ql  = acc_ql;
  assign tx_ql  = cur_ql;
  assign rx_los = (acc_ql != QL_NONE) && ql_worse(acc_ql, own);

  p_nomsg_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nomsg_evt |=> (rx_ql == 3'd7));
  p_dus_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && (clk_mode == 2'd0 || clk_mode == 2'd1)) |=> (tx_ql == 3'd5));
  p_track_regen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && clk_mode == 2'd2 && rx_ql != 3'd7) |=> (tx_ql == $past(rx_ql)));
  p_hold_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && clk_mode == 2'd3) |=> (tx_ql == $past(own_ql)));
endmodule

// File: tb/test_ssm_proc.sv
module test_ssm_proc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dl_stb = 1'b0, dl_bit = 1'b0;
  logic [15:0] nomsg_limit = 16'd64;
  logic [1:0]  clk_mode = 2'd0;
  logic [2:0]  own_ql = 3'd3;
  logic        tx_stb = 1'b0;
  logic        tx_bit, rx_los;
  logic [2:0]  rx_ql, tx_ql;

  int checks = 0, errors = 0;
  int m_hist[10];
  int m_rx = 7;
  bit m_aln = 0;

  always #5 clk = ~clk;

  ssm_proc i_ssm_proc (
    .clk(clk), .rst_n(rst_n), .dl_stb(dl_stb), .dl_bit(dl_bit),
    .nomsg_limit(nomsg_limit), .clk_mode(clk_mode), .own_ql(own_ql),
    .tx_stb(tx_stb), .tx_bit(tx_bit), .rx_ql(rx_ql), .rx_los(rx_los),
    .tx_ql(tx_ql));

  function automatic logic [15:0] bcode(int i);
    case (i)
      0: return 16'h04FF;  1: return 16'h08FF;  2: return 16'h0CFF;
      3: return 16'h7CFF;  4: return 16'h10FF;  5: return 16'h30FF;
      default: return 16'h5555;
    endcase
  endfunction

  function automatic int exp_tx(int mode, int rx, int own);
    if (mode == 2) return (rx == 7) ? 1 : rx;
    if (mode == 3) return own;
    return 5;
  endfunction

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < 10; i++) m_hist[i] = 7;
    m_rx = 7;
    m_aln = 0;
  endtask

  task automatic m_slot(int q);
    int cnt;
    if (!m_aln && q == 7) return;
    m_aln = 1;
    for (int i = 9; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = q;
    cnt = 0;
    for (int i = 0; i < 10; i++) if (m_hist[i] == q) cnt++;
    if (q != 7 && cnt >= 7) m_rx = q;
  endtask

  task automatic rx_one(logic b);
    @(negedge clk); dl_bit = b; dl_stb = 1'b1;
    @(negedge clk); dl_stb = 1'b0;
  endtask

  task automatic send_word(int i);
    logic [15:0] w;
    w = bcode(i);
    for (int k = 15; k >= 0; k--) rx_one(w[k]);
    m_slot((i >= 0 && i <= 5) ? i : 7);
  endtask

  task automatic read_word(output logic [15:0] w);
    for (int k = 15; k >= 0; k--) begin
      @(negedge clk); w[k] = tx_bit; tx_stb = 1'b1;
      @(negedge clk); tx_stb = 1'b0;
    end
  endtask

  initial begin
    logic [15:0] w;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_ql, 7, "R1 rx_ql");
    chk(rx_los, 0, "R1 rx_los");
    read_word(w);
    chk(w, 16'h30FF, "R1 first word");
    // R7 free run keeps do-not-use
    read_word(w);
    chk(w, 16'h30FF, "R7 free run word");
    // R8 tracking with nothing received -> unknown traceability
    clk_mode = 2'd2;
    read_word(w);          // selected at the end of the previous word
    chk(w, 16'h30FF, "R10 word already loaded");
    read_word(w);
    chk(w, 16'h08FF, "R8 no message code");
    // R9 holdover sends own level
    clk_mode = 2'd3; own_ql = 3'd2;
    read_word(w);
    chk(w, 16'h08FF, "R10 no switch mid run");
    read_word(w);
    chk(w, 16'h0CFF, "R9 own code");
    chk(tx_ql, 2, "R9 tx_ql");
    // R3 quorum: 6 repetitions not enough, 7 accepted
    own_ql = 3'd3;
    for (int n = 0; n < 6; n++) send_word(0);
    chk(rx_ql, 7, "R3 six repetitions");
    send_word(0);
    chk(rx_ql, 0, "R3 seventh repetition");
    chk(rx_los, 0, "R6 better than own");
    // R8 regeneration of received code (R2 bit order)
    clk_mode = 2'd2;
    read_word(w);
    read_word(w);
    chk(w, 16'h04FF, "R8 regenerated code");
    // R4 change needs new quorum
    for (int n = 0; n < 6; n++) send_word(4);
    chk(rx_ql, 0, "R4 old level kept");
    send_word(4);
    chk(rx_ql, 4, "R4 new level");
    chk(rx_los, 1, "R6 worse than own");
    for (int n = 0; n < 7; n++) send_word(3);
    chk(rx_ql, 3, "R2 stratum 3E code");
    chk(rx_los, 0, "R6 equal to own");
    // R5 timeout on the 64th strobe without a valid slot
    for (int n = 0; n < 63; n++) rx_one(1'b0);
    chk(rx_ql, 3, "R5 before limit");
    rx_one(1'b0);
    chk(rx_ql, 7, "R5 at limit");
    m_clear();
    // R11 corrupt slots dilute the vote
    send_word(0); send_word(6); send_word(0); send_word(0); send_word(6);
    send_word(0); send_word(0); send_word(6); send_word(0);
    chk(rx_ql, 7, "R11 six of nine");
    send_word(0);
    chk(rx_ql, 0, "R11 seven of ten");
    // random mixture against the bench model
    nomsg_limit = 16'd1000;
    void'($urandom(32'd2024));
    for (int it = 0; it < 40; it++) begin
      int q, reps, md, own;
      q = $urandom % 7;
      reps = 1 + $urandom % 9;
      own = $urandom % 6;
      md = $urandom % 4;
      own_ql = 3'(own);
      for (int n = 0; n < reps; n++) send_word(q);
      chk(rx_ql, m_rx, "R3 random level");
      chk(rx_los, (m_rx != 7 && m_rx > own) ? 1 : 0, "R6 random los");
      clk_mode = 2'(md);
      read_word(w);
      read_word(w);
      chk(w, bcode(exp_tx(md, m_rx, own)), "R8 random tx word");
      chk(tx_ql, exp_tx(md, m_rx, own), "R10 random tx_ql");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule